// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block is the address unit of a synchronous burst-capable static memory. On a rising clock edge where either of its two active-low address strobes is low, it captures a full external address. That address becomes the start of a burst. From then on, each rising edge where the active-low advance input is low and no strobe is low moves the burst one beat forward. Only the two lowest address bits take part in the burst; the upper bits keep the value they were loaded with.

A mode input picks how the low bits are formed. In linear order they count up modulo four from the loaded value. In interleaved order they are the loaded value XORed with the beat count. The block has no notion of read, write or output enable. Because of this, a read issued with the outputs disabled still steps the address like any other cycle with advance asserted.

The unit can also be used without bursts: a new address may be strobed in on every cycle. The outputs are the current full address and the beat position inside the burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low and after it is released, before any strobe, `addrOut` is 0 and `burstPos` is 0.
- R2: A rising edge with `strobeAN` low or `strobeBN` low (or both) loads `addrIn`. From that edge on, `addrOut` equals the loaded address and `burstPos` is 0.
- R3: A rising edge with both strobes high and `advanceN` low increments `burstPos` by one, modulo 4.
- R4: When a strobe and `advanceN` are low at the same edge, the load takes effect and no advance happens: `burstPos` becomes 0 and `addrOut` equals `addrIn`.
- R5: A rising edge with both strobes high and `advanceN` high leaves `burstPos` and the loaded address unchanged.
- R6: With `interleaveSel` = 0, `addrOut[1:0]` equals (loaded bits [1:0] + `burstPos`) mod 4, for example 1,2,3,0.
- R7: With `interleaveSel` = 1, `addrOut[1:0]` equals loaded bits [1:0] XOR `burstPos`, for example 2,3,0,1.
- R8: `addrOut` bits above bit 1 change only on a load. After four advances the low bits return to the start value, and further advances keep wrapping inside the same four-word block.
- R9: Strobes on consecutive edges each load their own address, with no cycle lost between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| addrIn | input | ADDR_W | External address captured on a load |
| strobeAN | input | 1 | First address strobe, active low |
| strobeBN | input | 1 | Second address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| interleaveSel | input | 1 | 0 = linear order, 1 = interleaved order |
| addrOut | output | ADDR_W | Current full address |
| burstPos | output | 2 | Beat position inside the burst |

## Verification
The bench aims at several corner cases, each with a distinct failure:
- A strobe and advance low at the same edge. A design that let advance win would show a beat position of 1 where 0 is expected.
- Bursts starting from low bits 1, 2 and 3 in both orders. A design that mixed up the two orders, or carried a linear wrap into bit 2, would show the wrong low bits or a changed upper address after the fourth beat.
- Strobes held low on consecutive edges, and the second strobe used alone. A design that ignored either strobe, or needed an idle cycle between loads, would show a stale address.
- Long random runs with idle cycles. These catch a design that drifts while neither strobe nor advance is asserted.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic load;   // capture external address, restart burst
    logic step;   // move one beat forward
  } burstCtrl_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic       strobeAN,
  input  logic       strobeBN,
  input  logic       advanceN,
  output burstCtrl_t ctrl
);
  logic loadReq;

  // Either strobe starts a burst; a load outranks an advance
  assign loadReq   = !strobeAN || !strobeBN;
  assign ctrl.load = loadReq;
  assign ctrl.step = !loadReq && !advanceN;
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtrl_t        ctrl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              interleaveSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic [CNT_W-1:0]  burstPos
);
  localparam int UPPER_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  beatCnt;
  logic [CNT_W-1:0]  startLow;
  logic [CNT_W-1:0]  linLow;
  logic [CNT_W-1:0]  intLow;
  logic [CNT_W-1:0]  lowBits;
  logic [UPPER_W-1:0] upperBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (ctrl.load) begin
      baseAddr <= addrIn;
      beatCnt  <= '0;
    end else if (ctrl.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  assign startLow  = baseAddr[CNT_W-1:0];
  assign upperBits = baseAddr[ADDR_W-1:CNT_W];
  assign linLow    = startLow + beatCnt;
  assign intLow    = startLow ^ beatCnt;

  always_comb begin
    if (interleaveSel) lowBits = intLow;
    else               lowBits = linLow;
  end

  assign addrOut  = {upperBits, lowBits};
  assign burstPos = beatCnt;

  // R5: idle edge keeps the loaded address and the beat count
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.step) |=> ($stable(baseAddr) && $stable(beatCnt)));

  // R3: a step moves the beat count by one, modulo the block size
  a_r3_step_count: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.step) |=> (beatCnt == CNT_W'($past(beatCnt) + 1'b1)));

  // R4: load and step never act together
  a_r4_load_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.load && ctrl.step));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              strobeAN,
  input  logic              strobeBN,
  input  logic              advanceN,
  input  logic              interleaveSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        burstPos
);
  localparam int CNT_W = 2;

  burstCtrl_t ctrl;
  logic anyStrobe;

  assign anyStrobe = !strobeAN || !strobeBN;

  burst_ctrl u_ctrl (
    .strobeAN (strobeAN),
    .strobeBN (strobeBN),
    .advanceN (advanceN),
    .ctrl     (ctrl)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .addrIn        (addrIn),
    .interleaveSel (interleaveSel),
    .addrOut       (addrOut),
    .burstPos      (burstPos)
  );

  // R2 / R4 / R9: any strobe loads the address, even with advance low
  a_r2_load_addr: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> (addrOut == $past(addrIn) && burstPos == 2'd0));

  // R8: upper bits move only on a load
  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    !anyStrobe |=> (addrOut[ADDR_W-1:CNT_W] == $past(addrOut[ADDR_W-1:CNT_W])));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addrIn;
  logic          strobeAN, strobeBN, advanceN, interleaveSel;
  logic [AW-1:0] addrOut;
  logic [1:0]    burstPos;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [AW-1:0] mBase;
  logic [1:0]    mCnt;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .strobeAN(strobeAN), .strobeBN(strobeBN), .advanceN(advanceN),
    .interleaveSel(interleaveSel), .addrOut(addrOut), .burstPos(burstPos)
  );

  function automatic logic [AW-1:0] expAddr(logic [AW-1:0] b, logic [1:0] c, logic il);
    logic [1:0] lo;
    lo = il ? (b[1:0] ^ c) : 2'(b[1:0] + c);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle, update the model at the edge, check after it
  task automatic cycle(logic sa, logic sb, logic adv, logic il, logic [AW-1:0] a,
                       string posTag);
    strobeAN = sa; strobeBN = sb; advanceN = adv; interleaveSel = il; addrIn = a;
    @(posedge clk);
    if (!sa || !sb) begin mBase = a; mCnt = 2'd0; end
    else if (!adv) mCnt = mCnt + 2'd1;
    @(negedge clk);
    check(posTag, {{(AW-2){1'b0}}, burstPos}, {{(AW-2){1'b0}}, mCnt});
    check(il ? "R7 interleaved addr" : "R6 linear addr", addrOut, expAddr(mBase, mCnt, il));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] upper;
    void'($urandom(32'd20240611));
    rstN = 1'b0; strobeAN = 1; strobeBN = 1; advanceN = 0; interleaveSel = 0;
    addrIn = 20'hABCDE;
    mBase = '0; mCnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset addr", addrOut, '0);
    check("R1 reset pos", {{(AW-2){1'b0}}, burstPos}, '0);
    rstN = 1'b1;
    cycle(1, 1, 1, 0, 20'h12345, "R1 hold after reset");
    check("R1 addr after release", addrOut, '0);

    // Linear burst from low bits 3, wrapping, upper fixed
    cycle(0, 1, 1, 0, 20'h5A5A7, "R2 load via A");
    upper = addrOut;
    for (int i = 0; i < 6; i++) cycle(1, 1, 0, 0, 20'h0, "R3 advance");
    check("R8 upper fixed after wrap", {addrOut[AW-1:2], 2'b00}, {upper[AW-1:2], 2'b00});
    check("R6 low after 6 beats", {{(AW-2){1'b0}}, addrOut[1:0]}, 20'h1);

    // Interleaved burst from 2: 2,3,0,1 then back to 2
    cycle(1, 0, 1, 1, 20'hF00F2, "R2 load via B");
    for (int i = 0; i < 4; i++) cycle(1, 1, 0, 1, 20'h0, "R3 advance il");
    check("R8 wrap returns start", addrOut, 20'hF00F2);

    // Idle keeps position
    cycle(1, 1, 0, 0, 20'h0, "R3 advance");
    cycle(1, 1, 1, 0, 20'hFFFFF, "R5 idle hold");
    cycle(1, 1, 1, 0, 20'h00000, "R5 idle hold");

    // Strobe and advance together
    cycle(0, 1, 0, 0, 20'h33331, "R4 load beats advance");
    cycle(0, 0, 0, 1, 20'h44442, "R4 both strobes plus advance");

    // Back-to-back loads
    for (int i = 0; i < 8; i++)
      cycle(i[0], !i[0], 1, i[1], AW'(32'h1111 * (i + 1)), "R9 back-to-back load");

    // Random mix
    for (int i = 0; i < 2000; i++) begin
      logic sa, sb, adv, il;
      string t;
      sa  = ($urandom_range(0, 3) != 0);
      sb  = ($urandom_range(0, 3) != 0);
      adv = $urandom_range(0, 1);
      il  = ($urandom_range(0, 7) == 0) ? !interleaveSel : interleaveSel;
      if (!sa || !sb) t = adv ? "R2 random load" : "R4 random load+adv";
      else            t = adv ? "R5 random idle" : "R3 random advance";
      cycle(sa, sb, adv, il, AW'($urandom()), t);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule